// File: doc/BRIEF.md
# Lookahead Priority Operation Scheduler

This block decides, every clock cycle, which pending operation of a network adapter controller may start. Fourteen operation classes raise requests on a fixed-position vector. Each class has a fixed priority and a fixed way of using the shared data bus: it starts a set number of cycles after its grant, holds the bus for a set number of cycles, and moves data in one direction. The block keeps a short reservation window of future bus use, built from its own earlier grants and from an external hold mask. It grants the highest-priority request whose bus cycles are all still free.

Internal state writes do not use the bus. One of them can be granted in the same cycle as a bus operation. The transmit class holds the bus for a length that only becomes known later, so its reservation stays open-ended until the length arrives. The SRAM behind the bus needs an idle cycle when it switches from read to write, and the scheduler leaves that gap. Bus operations that also touch the internal state port can clash with a state write in the same cycle. That clash is settled at the port: the operation granted earlier goes first, and the state write waits.

Top module: `lookahead_op_sched`

## Requirements
- R1: Request and grant bit k stand for one operation class. Among the bus classes the lowest index wins: 2 inbound-command compose, 3 ordered-queue high, 4 ordered-queue low, 5 ordered-queue compose, 6 service-side data motion, 7 application-side data motion, 8 service-side compose, 9 application-side compose, 10 DMA write, 11 receive, 12 transmit, 13 DMA transmit.
- R2: At most one of grant bits 2 to 13 is set in any cycle.
- R3: Bit 0 (service-side state write) and bit 1 (application-side state write) are granted independently of the bus classes, in the same cycle as a bus grant if one is made. Bit 0 outranks bit 1. A new state write is granted only when no earlier state write is still waiting, or when the waiting one reaches the port in this same cycle.
- R4: A bus class granted in cycle t uses the bus from cycle t+S for L cycles, in direction D. The (S, L, D) values are: 2, 5, 8, 9 → (1, 1, write); 3, 4 → (1, 2, read); 6, 7, 10 → (2, 2, write); 11 → (1, 3, write); 13 → (1, 3, read). A class is granted only if none of its cycles is already reserved. It is also not granted if ext_hold_i bit i-1 is set for a cycle t+i that it needs. bus_busy_o and bus_rd_o show the bus use in the current cycle.
- R5: A write-use cycle never directly follows a read-use cycle. A write class is refused if the cycle just before its first bus cycle is a read. A read class is refused if the cycle just after its last bus cycle is a write.
- R6: Transmit (bit 12) is granted only when the bus is unreserved for the next LOOK cycles. It reads on the bus from t+1. From t+1 onward no bus class is granted until tx_len_vld_i arrives in cycle t+2. tx_len_i (2 to 15) then gives the total number of bus cycles, counted from t+1.
- R7: Classes 2, 3, 4, 5, 8, 9, 11 and 12 access the internal state port in cycle t+2 after their grant in cycle t, shown on port_bo_go_o.
- R8: A state write granted in cycle t uses the port in cycle t+1. If port_bo_go_o is high in that cycle, wr_stall_o is raised and the write retries in the next cycle. port_wr_go_o marks the cycle the write reaches the port, and port_wr_src_o is 1 then if the write came from the application side.
- R9: While reset is held, every output is 0 whatever the requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 14 | Pending request per operation class |
| ext_hold_i | input | LOOK | Bit i-1 marks cycle t+i as held by another user |
| tx_len_vld_i | input | 1 | Transmit length valid, two cycles after the transmit grant |
| tx_len_i | input | TXLEN_W | Transmit bus length in cycles |
| gnt_o | output | 14 | Grants, one bit per class |
| port_bo_go_o | output | 1 | A bus class uses the state port this cycle |
| port_wr_go_o | output | 1 | A state write uses the state port this cycle |
| port_wr_src_o | output | 1 | Side of the write on the port (1 = application) |
| wr_stall_o | output | 1 | The waiting state write lost the port this cycle |
| bus_busy_o | output | 1 | Bus in use this cycle |
| bus_rd_o | output | 1 | Current bus use is a read |

## Verification
Sparse random request vectors with an occasional external hold mask exercise priority among classes that fit. They also show whether the reservation window tracks overlapping start offsets and lengths. Dense vectors with every request raised separate the priority order from the fit test. Hand-built sequences each isolate one rule: a read class followed by a write class isolates the turnaround gap. A transmit followed by full requests isolates the open-ended hold. A pointer-touching bus class granted one cycle before a state write isolates the port stall and its retry.

// File: rtl/opsched_pkg.sv
package opsched_pkg;
  localparam int NUM_OPS      = 14;
  localparam int FIRST_BUS_OP = 2;

  localparam int OP_SP_STW  = 0;
  localparam int OP_AP_STW  = 1;
  localparam int OP_INB_CMP = 2;
  localparam int OP_ORD_HI  = 3;
  localparam int OP_ORD_LO  = 4;
  localparam int OP_ORD_CMP = 5;
  localparam int OP_SP_MOV  = 6;
  localparam int OP_AP_MOV  = 7;
  localparam int OP_SP_CMP  = 8;
  localparam int OP_AP_CMP  = 9;
  localparam int OP_DMA_WR  = 10;
  localparam int OP_RCV     = 11;
  localparam int OP_XMT     = 12;
  localparam int OP_DMA_XMT = 13;

  // Resource profile of one operation class
  typedef struct packed {
    logic       bus;   // uses the shared data bus
    logic       open;  // bus hold length learned after grant
    logic       rd;    // bus direction: 1 = SRAM read
    logic       st;    // touches internal state port at grant+2
    logic [1:0] ofs;   // first bus cycle relative to grant
    logic [1:0] len;   // bus cycles held
  } op_prof_t;

  function automatic op_prof_t op_prof(input int k);
    op_prof_t p;
    p = '0;
    case (k)
      OP_INB_CMP, OP_ORD_CMP, OP_SP_CMP, OP_AP_CMP:
        p = '{bus:1'b1, open:1'b0, rd:1'b0, st:1'b1, ofs:2'd1, len:2'd1};
      OP_ORD_HI, OP_ORD_LO:
        p = '{bus:1'b1, open:1'b0, rd:1'b1, st:1'b1, ofs:2'd1, len:2'd2};
      OP_SP_MOV, OP_AP_MOV, OP_DMA_WR:
        p = '{bus:1'b1, open:1'b0, rd:1'b0, st:1'b0, ofs:2'd2, len:2'd2};
      OP_RCV:
        p = '{bus:1'b1, open:1'b0, rd:1'b0, st:1'b1, ofs:2'd1, len:2'd3};
      OP_XMT:
        p = '{bus:1'b1, open:1'b1, rd:1'b1, st:1'b1, ofs:2'd1, len:2'd0};
      OP_DMA_XMT:
        p = '{bus:1'b1, open:1'b0, rd:1'b1, st:1'b0, ofs:2'd1, len:2'd3};
      default: p = '0;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/opsched_window.sv
module opsched_window
  import opsched_pkg::*;
#(
  parameter int LOOK = 3,
  parameter int LW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            gv,
  input  op_prof_t        gp,
  input  logic            tx_len_vld,
  input  logic [LW-1:0]   tx_len,
  input  logic [LOOK-1:0] ext_hold,
  output logic [LOOK:0]   occ,
  output logic [LOOK:0]   rdr,
  output logic [LOOK:0]   wrr,
  output logic            tx_open,
  output logic            bus_busy,
  output logic            bus_rd
);
  // slot i of the window is cycle now+i
  logic [LOOK:0]  wb_q, wb_d, rb_q, rb_d, wb_sh, rb_sh, hit, txcov;
  logic [1:0]     ph_q, ph_d;
  logic [LW-1:0]  left_q, left_d;
  logic           ph_en, left_en, prev_rd_q;
  logic           unused_st;

  assign unused_st = gp.st;
  assign tx_open   = (ph_q != 2'd0);

  always_comb begin
    for (int i = 0; i <= LOOK; i++) begin
      txcov[i] = tx_open || (int'(left_q) > i);
      rdr[i]   = (wb_q[i] & rb_q[i]) | txcov[i];
      wrr[i]   = wb_q[i] & ~rb_q[i];
    end
    occ[0] = wb_q[0] | txcov[0];
    for (int i = 1; i <= LOOK; i++) begin
      occ[i] = wb_q[i] | txcov[i] | ext_hold[i-1];
    end
  end

  assign bus_busy = wb_q[0] | txcov[0];
  assign bus_rd   = (wb_q[0] & rb_q[0]) | txcov[0];

  // Window advance plus new reservation
  assign wb_sh = {1'b0, wb_q[LOOK:1]};
  assign rb_sh = {1'b0, rb_q[LOOK:1] & wb_q[LOOK:1]};

  always_comb begin
    for (int j = 0; j <= LOOK; j++) begin
      hit[j]  = gv && gp.bus && !gp.open &&
                (j + 1 >= int'(gp.ofs)) &&
                (j + 1 <= int'(gp.ofs) + int'(gp.len) - 1);
      wb_d[j] = wb_sh[j] | hit[j];
      rb_d[j] = rb_sh[j] | (hit[j] & gp.rd);
    end
  end

  // Open-ended transmit tracking
  always_comb begin
    ph_d   = ph_q;
    left_d = left_q;
    case (ph_q)
      2'd0:    if (gv && gp.open) ph_d = 2'd1;
      2'd1:    ph_d = 2'd2;
      default: if (tx_len_vld) ph_d = 2'd0;
    endcase
    if (ph_q == 2'd2 && tx_len_vld) left_d = tx_len - LW'(2);
    else if (left_q != '0)          left_d = left_q - LW'(1);
  end

  assign ph_en   = tx_open | (gv & gp.open);
  assign left_en = (ph_q == 2'd2 && tx_len_vld) || (left_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q      <= '0;
      rb_q      <= '0;
      ph_q      <= 2'd0;
      left_q    <= '0;
      prev_rd_q <= 1'b0;
    end else begin
      wb_q      <= wb_d;
      rb_q      <= rb_d;
      prev_rd_q <= bus_busy & bus_rd;
      if (ph_en)   ph_q   <= ph_d;
      if (left_en) left_q <= left_d;
    end
  end

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    prev_rd_q |-> !(bus_busy && !bus_rd));

  assert_len_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_len_vld |-> (ph_q == 2'd2 && tx_len >= LW'(2)));
endmodule

// File: rtl/opsched_pick.sv
module opsched_pick
  import opsched_pkg::*;
#(
  parameter int LOOK = 3
) (
  input  logic               en,
  input  logic [NUM_OPS-1:0] req,
  input  logic [LOOK:0]      occ,
  input  logic [LOOK:0]      rdr,
  input  logic [LOOK:0]      wrr,
  input  logic               wr_ok,
  output logic [NUM_OPS-1:0] gnt,
  output logic               bus_gv,
  output op_prof_t           bus_prof
);
  logic [NUM_OPS-1:FIRST_BUS_OP] fit, elig, gsel;
  logic unused_slots;

  assign unused_slots = ^{occ[0], rdr, wrr};

  for (genvar k = FIRST_BUS_OP; k < NUM_OPS; k++) begin : g_fit
    localparam op_prof_t P = op_prof(k);
    localparam int S = int'(P.ofs);
    localparam int E = int'(P.ofs) + int'(P.len) - 1;
    if (P.open) begin : g_open
      assign fit[k] = ~|occ[LOOK:1];
    end else begin : g_fixed
      logic free, turn_ok;
      always_comb begin
        free = 1'b1;
        for (int i = 1; i <= LOOK; i++) begin
          if (i >= S && i <= E && occ[i]) free = 1'b0;
        end
      end
      if (!P.rd) begin : g_wr
        assign turn_ok = ~rdr[S-1];
      end else if (E + 1 <= LOOK) begin : g_rd
        assign turn_ok = ~wrr[E+1];
      end else begin : g_rd_end
        assign turn_ok = 1'b1;
      end
      assign fit[k] = free & turn_ok;
    end
  end

  assign elig = req[NUM_OPS-1:FIRST_BUS_OP] & fit & {(NUM_OPS-FIRST_BUS_OP){en}};

  always_comb begin
    gsel     = '0;
    bus_prof = '0;
    for (int k = NUM_OPS - 1; k >= FIRST_BUS_OP; k--) begin
      if (elig[k]) begin
        gsel    = '0;
        gsel[k] = 1'b1;
        bus_prof = op_prof(k);
      end
    end
  end

  assign bus_gv = |gsel;
  assign gnt    = {gsel,
                   en & wr_ok & req[OP_AP_STW] & ~req[OP_SP_STW],
                   en & wr_ok & req[OP_SP_STW]};
endmodule

// File: rtl/opsched_port.sv
module opsched_port (
  input  logic clk,
  input  logic rst_n,
  input  logic bo_st_g,
  input  logic wr_g,
  input  logic wr_src_i,
  output logic port_bo_go,
  output logic port_wr_go,
  output logic port_wr_src,
  output logic wr_stall,
  output logic wr_ok
);
  logic s1_q, s2_q, pend_q, pend_d, src_q, src_d;

  assign port_bo_go  = s2_q;
  assign port_wr_go  = pend_q & ~s2_q;
  assign wr_stall    = pend_q & s2_q;
  assign port_wr_src = src_q & port_wr_go;
  assign wr_ok       = ~pend_q | port_wr_go;

  always_comb begin
    pend_d = pend_q;
    src_d  = src_q;
    if (port_wr_go) pend_d = 1'b0;
    if (wr_g) begin
      pend_d = 1'b1;
      src_d  = wr_src_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      pend_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      s1_q   <= bo_st_g;
      s2_q   <= s1_q;
      pend_q <= pend_d;
      if (wr_g) src_q <= src_d;
    end
  end

  assert_stall_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stall |=> (port_wr_go || wr_stall));
endmodule

// File: rtl/lookahead_op_sched.sv
module lookahead_op_sched
  import opsched_pkg::*;
#(
  parameter int LOOK    = 3,
  parameter int TXLEN_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_OPS-1:0] req_i,
  input  logic [LOOK-1:0]    ext_hold_i,
  input  logic               tx_len_vld_i,
  input  logic [TXLEN_W-1:0] tx_len_i,
  output logic [NUM_OPS-1:0] gnt_o,
  output logic               port_bo_go_o,
  output logic               port_wr_go_o,
  output logic               port_wr_src_o,
  output logic               wr_stall_o,
  output logic               bus_busy_o,
  output logic               bus_rd_o
);
  logic [1:0]    rs_q;
  logic          rst_q;
  logic [LOOK:0] occ, rdr, wrr;
  logic          tx_open, bus_gv, wr_ok, bo_st_g, wr_g;
  op_prof_t      bus_prof;

  // Reset asserts at once, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  opsched_window #(.LOOK(LOOK), .LW(TXLEN_W)) u_win (
    .clk(clk), .rst_n(rst_q), .gv(bus_gv), .gp(bus_prof),
    .tx_len_vld(tx_len_vld_i), .tx_len(tx_len_i), .ext_hold(ext_hold_i),
    .occ(occ), .rdr(rdr), .wrr(wrr), .tx_open(tx_open),
    .bus_busy(bus_busy_o), .bus_rd(bus_rd_o)
  );

  opsched_pick #(.LOOK(LOOK)) u_pick (
    .en(rst_q), .req(req_i), .occ(occ), .rdr(rdr), .wrr(wrr),
    .wr_ok(wr_ok), .gnt(gnt_o), .bus_gv(bus_gv), .bus_prof(bus_prof)
  );

  assign bo_st_g = bus_gv & bus_prof.st;
  assign wr_g    = gnt_o[OP_SP_STW] | gnt_o[OP_AP_STW];

  opsched_port u_port (
    .clk(clk), .rst_n(rst_q), .bo_st_g(bo_st_g), .wr_g(wr_g),
    .wr_src_i(gnt_o[OP_AP_STW]), .port_bo_go(port_bo_go_o),
    .port_wr_go(port_wr_go_o), .port_wr_src(port_wr_src_o),
    .wr_stall(wr_stall_o), .wr_ok(wr_ok)
  );

  assert_bus_onehot_R2: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(gnt_o[NUM_OPS-1:FIRST_BUS_OP]));

  assert_sp_rank_R3: assert property (@(posedge clk) disable iff (!rst_q)
    gnt_o[OP_AP_STW] |-> !req_i[OP_SP_STW]);

  assert_tx_hold_R6: assert property (@(posedge clk) disable iff (!rst_q)
    tx_open |-> !bus_gv);

  assert_port_lat_R7: assert property (@(posedge clk) disable iff (!rst_q)
    bo_st_g |-> ##2 port_bo_go_o);
endmodule

// File: tb/sim_lookahead_op_sched.sv
`timescale 1ns/1ps
module sim_lookahead_op_sched;
  localparam int LOOK = 3;
  localparam int LW   = 4;
  localparam int N    = 14;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic [LOOK-1:0] ext;
  logic          lenv;
  logic [LW-1:0] len;
  logic [N-1:0]  gnt;
  logic          bo_go, wgo, wsrc_o, stall, busy, brd;

  always #10 clk = ~clk;

  lookahead_op_sched #(.LOOK(LOOK), .TXLEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .ext_hold_i(ext),
    .tx_len_vld_i(lenv), .tx_len_i(len), .gnt_o(gnt),
    .port_bo_go_o(bo_go), .port_wr_go_o(wgo), .port_wr_src_o(wsrc_o),
    .wr_stall_o(stall), .bus_busy_o(busy), .bus_rd_o(brd)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  // reference model, slot i = now+i
  bit mb[0:15], mr[0:15];
  int txph;
  bit s1, s2, wpend, wsrc;
  logic [N-1:0] g_act;
  logic a_bo, a_wgo, a_src, a_stall;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic void prof(input int k, output int s, output int l,
                               output bit rd, output bit st, output bit op);
    s = 1; l = 1; rd = 0; st = 1; op = 0;
    case (k)
      3, 4:      begin l = 2; rd = 1; end
      6, 7, 10:  begin s = 2; l = 2; st = 0; end
      11:        l = 3;
      12:        begin op = 1; rd = 1; l = 0; end
      13:        begin l = 3; rd = 1; st = 0; end
      default:   ;
    endcase
  endfunction

  function automatic bit occ_m(input int i);
    return (txph != 0) || mb[i] || (i >= 1 && ext[i-1]);
  endfunction

  function automatic bit fits(input int k);
    int s, l; bit rd, st, op;
    prof(k, s, l, rd, st, op);
    if (op) return !occ_m(1) && !occ_m(2) && !occ_m(3);
    for (int i = s; i < s + l; i++) if (occ_m(i)) return 0;
    if (!rd && ((txph != 0) || (mb[s-1] && mr[s-1]))) return 0;
    if (rd && (s + l <= LOOK) && mb[s+l] && !mr[s+l]) return 0;
    return 1;
  endfunction

  task automatic step(input logic [N-1:0] rq, input logic [LOOK-1:0] ex);
    logic [N-1:0] eg;
    bit e_bo, e_wgo, e_stall, wok;
    int kg, s, l, ln; bit rd, st, op;
    @(negedge clk);
    req = rq; ext = ex;
    lenv = (txph == 2);
    ln = 2 + int'($urandom % 9);
    len = lenv ? LW'(ln) : '0;
    #1;
    e_bo = s2; e_wgo = wpend && !s2; e_stall = wpend && s2;
    wok = !wpend || e_wgo;
    eg = '0; kg = -1;
    for (int k = 2; k < N; k++) if (kg < 0 && rq[k] && fits(k)) kg = k;
    if (kg >= 0) eg[kg] = 1'b1;
    if (wok && rq[0]) eg[0] = 1'b1;
    else if (wok && rq[1]) eg[1] = 1'b1;
    chk("R1 bus grant", 32'(gnt[N-1:2]), 32'(eg[N-1:2]));
    chk("R2 bus grant count", 32'($countones(gnt[N-1:2]) <= 1), 32'd1);
    chk("R3 state-write grant", 32'(gnt[1:0]), 32'(eg[1:0]));
    chk("R7 bus-class port use", 32'(bo_go), 32'(e_bo));
    chk("R8 write port use", 32'(wgo), 32'(e_wgo));
    chk("R8 write stall", 32'(stall), 32'(e_stall));
    chk("R8 write source", 32'(wsrc_o), 32'(e_wgo && wsrc));
    chk("R4 bus busy", 32'(busy), 32'(mb[0] || txph != 0));
    chk("R5 bus direction", 32'(brd), 32'((mb[0] && mr[0]) || txph != 0));
    g_act = gnt; a_bo = bo_go; a_wgo = wgo; a_src = wsrc_o; a_stall = stall;
    // advance model
    if (txph == 2 && lenv) begin
      for (int i = 1; i <= ln - 2; i++) begin mb[i] = 1; mr[i] = 1; end
      txph = 0;
    end else if (txph == 1) txph = 2;
    st = 0;
    if (kg >= 0) begin
      prof(kg, s, l, rd, st, op);
      if (op) begin
        mb[1] = 1; mr[1] = 1; mb[2] = 1; mr[2] = 1; txph = 1;
      end else begin
        for (int i = s; i < s + l; i++) begin mb[i] = 1; mr[i] = rd; end
      end
    end
    for (int i = 0; i < 15; i++) begin mb[i] = mb[i+1]; mr[i] = mr[i+1]; end
    mb[15] = 0; mr[15] = 0;
    s2 = s1; s1 = st;
    if (e_wgo) wpend = 0;
    if (eg[0] || eg[1]) begin wpend = 1; wsrc = eg[1]; end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 16; i++) begin mb[i] = 0; mr[i] = 0; end
    txph = 0; s1 = 0; s2 = 0; wpend = 0; wsrc = 0;
    rst_n = 1'b0; req = '1; ext = '0; lenv = 1'b0; len = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9 reset grants", 32'(gnt), 32'd0);
    chk("R9 reset bus", 32'({busy, brd}), 32'd0);
    chk("R9 reset port", 32'({bo_go, wgo, wsrc_o, stall}), 32'd0);
    req = '0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // all requests: SP state write plus top bus class
    step('1, '0);
    chk("R1 full request", 32'(g_act), 32'h0005);
    repeat (6) step('0, '0);

    // open-ended transmit
    step(N'(1) << 12, '0);
    chk("R6 transmit grant", 32'(g_act), 32'h1000);
    step(14'h3FFC, '0);
    chk("R6 hold before length", 32'(g_act), 32'h0);
    step(14'h3FFC, '0);
    chk("R6 hold at length", 32'(g_act), 32'h0);
    repeat (18) step('0, '0);

    // read then write turnaround
    step(N'(1) << 3, '0);
    chk("R4 ordered read grant", 32'(g_act), 32'h0008);
    step(N'(1) << 8, '0);
    chk("R4 overlap refused", 32'(g_act), 32'h0);
    step(N'(1) << 8, '0);
    chk("R5 turnaround refused", 32'(g_act), 32'h0);
    step(N'(1) << 8, '0);
    chk("R5 after gap", 32'(g_act), 32'h0100);
    repeat (6) step('0, '0);

    // state port conflict
    step(N'(1) << 8, '0);
    chk("R7 pointer class grant", 32'(g_act), 32'h0100);
    step(N'(1) << 1, '0);
    chk("R3 AP write grant", 32'(g_act), 32'h0002);
    step('0, '0);
    chk("R8 stall on clash", 32'({a_bo, a_stall}), 32'h3);
    step('0, '0);
    chk("R8 retry reaches port", 32'({a_wgo, a_src}), 32'h3);
    repeat (4) step('0, '0);

    // random traffic
    for (int c = 0; c < 3000; c++) begin
      logic [N-1:0] rq;
      logic [LOOK-1:0] ex;
      rq = N'($urandom & $urandom);
      ex = ($urandom % 4 == 0) ? LOOK'($urandom) : '0;
      step(rq, ex);
    end
    repeat (20) step('0, '0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R9 watchdog act=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule